// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a five-digit decimal conversion result on a time-shared output. Each digit is a 4-bit BCD value. The block walks a set of one-hot select lines from the most significant digit down to the least significant one. While a digit is selected, its BCD code sits on a shared 4-bit bus. Each select position is held for a fixed number of clock counts, and the walk then starts again at the top.

Results arrive on a valid-qualified input. There is no ready signal: a result is accepted in any cycle. A result that arrives before an earlier one has gone on display replaces it, so only the most recent one is kept. An accepted result goes on the bus only when the next scan begins. After that, one strobe pulse is issued per digit for that first scan only. A processor or serial transmitter can use the strobe to capture each digit in the middle of its slot.

An over-range level input changes the scan. Slots become much longer, and the bus is forced to zero on every second scan so that a display flashes.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the most significant select line (`digit_sel[4]`) is the only one high, `bcd_out` is 0 and `strobe` is low.
- R2: Exactly one bit of `digit_sel` is high in every cycle. Bit i selects the digit with decimal weight 10^i. The selection moves from bit 4 down to bit 0 and then returns to bit 4.
- R3: Each select position lasts DWELL cycles. When a scan puts a newly taken result on display, its bit-4 slot lasts DWELL+1 cycles.
- R4: During the slot of bit i, `bcd_out` equals bits [4i+3:4i] of the displayed result, with bit 0 having weight 1. `bcd_out` does not change inside a slot.
- R5: In the first scan after a result is taken up, `strobe` is high for exactly STROBE_LEN consecutive cycles in each slot. The pulse starts at cycle offset floor((slot length − STROBE_LEN)/2) from the start of the slot. In all other scans `strobe` stays low.
- R6: A result offered with `res_valid` in any cycle is taken up only when the current scan ends. A scan never shows digits from two different results. If a later result arrives before that boundary, it replaces the earlier one.
- R7: A result offered in the cycle whose clock edge ends a scan is not used for the scan that starts at that edge. It is displayed, with strobes, from the scan after that.
- R8: `over_range` is sampled when a scan starts. In a scan that began with it high, every slot lasts OVR_DWELL cycles, or OVR_DWELL+1 for a bit-4 slot that takes up a new result.
- R9: In consecutive over-range scans, the first scan shows the digits and the next forces `bcd_out` to 0, alternating from then on. A scan that takes up a new result is always shown, and the alternation restarts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle qualifier for `res_digits`; always accepted |
| res_digits | input | 20 | Five BCD digits; bits [4i+3:4i] hold the digit of weight 10^i |
| over_range | input | 1 | Over-range level, sampled at each scan start |
| digit_sel | output | 5 | One-hot digit select; bit 4 is the most significant digit |
| bcd_out | output | 4 | BCD code of the selected digit, or 0 when blanked |
| strobe | output | 1 | Capture pulse centred in each slot of the first scan after a new result |

## Verification
Two functions can fall in the same cycle: a new result being offered, and the clock edge that ends a scan and takes up the pending value. The bench measures the length of a plain scan. It then raises `res_valid` in the exact last cycle of the D1 slot, so that the offer lands on the scan-end edge. The scan that starts at that edge must still show the old digits without strobes. The scan after it must show the new digits, with strobes and a lengthened first slot. Two related cases are also checked: two offers inside one scan, where the later one must win, and a new result arriving during a blanked over-range scan.

// File: rtl/bds_pkg.sv
package bds_pkg;
  localparam int unsigned BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/bds_slot_timer.sv
module bds_slot_timer
  import bds_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned DWELL      = 200,
  parameter int unsigned OVR_DWELL  = 1000,
  localparam int unsigned MAXLEN    = (OVR_DWELL > DWELL) ? OVR_DWELL : DWELL,
  localparam int unsigned CNT_W     = $clog2(MAXLEN + 2),
  localparam int unsigned SLOT_W    = $clog2(NUM_DIGITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_i,
  input  logic              long_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              scan_end_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_DIGITS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  base;
  logic              slot_end;

  always_comb begin
    base       = wide_i ? CNT_W'(OVR_DWELL) : CNT_W'(DWELL);
    len_o      = base + ((long_i && slot_q == '0) ? CNT_W'(1) : '0);
    slot_end   = (cnt_q == len_o - CNT_W'(1));
    scan_end_o = slot_end && (slot_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (slot_end) begin
      cnt_q  <= '0;
      slot_q <= (slot_q == LAST) ? '0 : slot_q + SLOT_W'(1);
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign slot_o = slot_q;
  assign cnt_o  = cnt_q;

  // R3: the dwell counter never runs past the slot length in force
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q < len_o);
endmodule

// File: rtl/bds_result_latch.sv
module bds_result_latch
  import bds_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  localparam int unsigned DIG_W     = NUM_DIGITS * BCD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [DIG_W-1:0] res_digits,
  input  logic             over_range,
  input  logic             scan_end,
  output logic [DIG_W-1:0] shown_o,
  output logic             wide_o,
  output logic             fresh_o,
  output logic             blank_o
);
  logic [DIG_W-1:0] pend_q, shown_q;
  logic             pend_v, wide_q, fresh_q, flash_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      pend_v  <= 1'b0;
      shown_q <= '0;
      wide_q  <= 1'b0;
      fresh_q <= 1'b0;
      flash_q <= 1'b0;
    end else begin
      if (res_valid) begin
        pend_q <= res_digits;
        pend_v <= 1'b1;
      end else if (scan_end) begin
        pend_v <= 1'b0;
      end
      if (scan_end) begin
        wide_q  <= over_range;
        fresh_q <= pend_v;
        if (pend_v) shown_q <= pend_q;
        if (!over_range || pend_v) flash_q <= 1'b0;
        else if (wide_q)           flash_q <= ~flash_q;
        else                       flash_q <= 1'b0;
      end
    end
  end

  assign shown_o = shown_q;
  assign wide_o  = wide_q;
  assign fresh_o = fresh_q;
  assign blank_o = wide_q & flash_q;

  // R6: displayed digits change only on a scan-end edge
  p_adopt_edge_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(shown_q) |-> $past(scan_end));
  // R7: an offer landing on the scan-end edge stays pending
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && scan_end) |=> pend_v);
  // R9: blanking begins only at a scan boundary
  p_blank_edge_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(blank_o) |-> $past(scan_end));
endmodule

// File: rtl/bds_strobe_gen.sv
module bds_strobe_gen #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned STROBE_LEN = 100
) (
  input  logic             fresh,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] len,
  output logic             strobe
);
  logic [CNT_W-1:0] start, stop;

  always_comb begin
    start  = (len - CNT_W'(STROBE_LEN)) >> 1;
    stop   = start + CNT_W'(STROBE_LEN);
    strobe = fresh && (cnt >= start) && (cnt < stop);
  end
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import bds_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned DWELL      = 200,
  parameter int unsigned OVR_DWELL  = 1000,
  parameter int unsigned STROBE_LEN = 100
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        res_valid,
  input  logic [NUM_DIGITS*BCD_W-1:0] res_digits,
  input  logic                        over_range,
  output logic [NUM_DIGITS-1:0]       digit_sel,
  output logic [BCD_W-1:0]            bcd_out,
  output logic                        strobe
);
  localparam int unsigned DIG_W  = NUM_DIGITS * BCD_W;
  localparam int unsigned MAXLEN = (OVR_DWELL > DWELL) ? OVR_DWELL : DWELL;
  localparam int unsigned CNT_W  = $clog2(MAXLEN + 2);
  localparam int unsigned SLOT_W = $clog2(NUM_DIGITS);

  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  cnt, len;
  logic              scan_end, wide, fresh, blank;
  logic [DIG_W-1:0]  shown;
  bcd_t              cur;

  bds_slot_timer #(.NUM_DIGITS(NUM_DIGITS), .DWELL(DWELL), .OVR_DWELL(OVR_DWELL)) u_timer (
    .clk(clk), .rst(rst), .wide_i(wide), .long_i(fresh),
    .slot_o(slot), .cnt_o(cnt), .len_o(len), .scan_end_o(scan_end)
  );

  bds_result_latch #(.NUM_DIGITS(NUM_DIGITS)) u_latch (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_digits(res_digits),
    .over_range(over_range), .scan_end(scan_end),
    .shown_o(shown), .wide_o(wide), .fresh_o(fresh), .blank_o(blank)
  );

  bds_strobe_gen #(.CNT_W(CNT_W), .STROBE_LEN(STROBE_LEN)) u_strobe (
    .fresh(fresh), .cnt(cnt), .len(len), .strobe(strobe)
  );

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
    assign digit_sel[g] = (slot == SLOT_W'(NUM_DIGITS - 1 - g));
  end

  always_comb begin
    cur     = shown[(NUM_DIGITS - 1 - int'(slot)) * BCD_W +: BCD_W];
    bcd_out = blank ? '0 : cur;
  end

  // R2: selection steps down one position, or wraps from the last digit to the first
  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(digit_sel) |->
      (digit_sel == ($past(digit_sel) >> 1)) ||
      ($past(digit_sel) == NUM_DIGITS'(1) && digit_sel == NUM_DIGITS'(1) << (NUM_DIGITS - 1)));
  // R4: the bus holds its value while the selection holds
  p_bus_steady_r4: assert property (@(posedge clk) disable iff (rst)
    $stable(digit_sel) |-> $stable(bcd_out));
  // R5: a strobe pulse never starts on a slot's first cycle
  p_strobe_inside_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> $stable(digit_sel) && $stable(bcd_out));
endmodule

// File: tb/bcd_digit_scanner_bench.sv
`timescale 1ns/1ps
module bcd_digit_scanner_bench;
  localparam int ND = 5;
  localparam int DW = 20;
  localparam int OW = 40;
  localparam int SL = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          res_valid = 1'b0;
  logic [19:0]   res_digits = '0;
  logic          over_range = 1'b0;
  logic [ND-1:0] digit_sel;
  logic [3:0]    bcd_out;
  logic          strobe;

  int checks = 0;
  int fails  = 0;
  int g_len[ND], g_val[ND], g_stb[ND], g_off[ND];
  int g_bad_hot, g_bad_stable;

  always #2 clk = ~clk;

  bcd_digit_scanner #(.NUM_DIGITS(ND), .DWELL(DW), .OVR_DWELL(OW), .STROBE_LEN(SL)) u_bcd_digit_scanner (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_digits(res_digits),
    .over_range(over_range), .digit_sel(digit_sel), .bcd_out(bcd_out), .strobe(strobe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [19:0] d);
    res_digits = d;
    res_valid  = 1'b1;
    @(negedge clk);
    res_valid  = 1'b0;
  endtask

  task automatic sync_d5();
    logic [ND-1:0] p;
    bit found = 0;
    p = digit_sel;
    while (!found) begin
      @(negedge clk);
      if (p == 5'b00001 && digit_sel == 5'b10000) found = 1;
      p = digit_sel;
    end
  endtask

  // entered in the first cycle of a D5 slot; returns in the first cycle of the next one
  task automatic grab_scan();
    g_bad_hot = 0;
    g_bad_stable = 0;
    for (int s = 0; s < ND; s++) begin
      logic [ND-1:0] e;
      int l = 0;
      e = 5'b10000 >> s;
      g_val[s] = bcd_out;
      g_stb[s] = 0;
      g_off[s] = -1;
      while (digit_sel == e && l < 3000) begin
        if ($countones(digit_sel) != 1) g_bad_hot++;
        if (bcd_out != g_val[s]) g_bad_stable++;
        if (strobe) begin
          if (g_off[s] < 0) g_off[s] = l;
          g_stb[s]++;
        end
        l++;
        @(negedge clk);
      end
      g_len[s] = l;
    end
  endtask

  task automatic expect_scan(input string vtag, input logic [19:0] d,
                             input bit fresh, input bit wide, input bit blanked);
    for (int s = 0; s < ND; s++) begin
      int el;
      el = (wide ? OW : DW) + ((fresh && s == 0) ? 1 : 0);
      chk(wide ? "R8" : "R3", $sformatf("slot %0d length", s), g_len[s], el);
      chk(vtag, $sformatf("slot %0d bcd", s), g_val[s], blanked ? 0 : int'(d[(ND-1-s)*4 +: 4]));
      chk("R5", $sformatf("slot %0d strobe cycles", s), g_stb[s], fresh ? SL : 0);
      if (fresh) chk("R5", $sformatf("slot %0d strobe offset", s), g_off[s], (el - SL) / 2);
    end
    chk("R2", "cycles without exactly one select", g_bad_hot, 0);
    chk("R4", "bcd changes inside a slot", g_bad_stable, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "digit_sel in reset", digit_sel, 5'b10000);
    chk("R1", "bcd in reset", bcd_out, 0);
    chk("R1", "strobe in reset", strobe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "digit_sel after reset", digit_sel, 5'b10000);
    chk("R1", "bcd after reset", bcd_out, 0);
    chk("R1", "strobe after reset", strobe, 0);
  endtask

  task automatic t_basic();
    sync_d5();
    repeat (30) @(negedge clk);
    send(20'h54321);
    sync_d5();
    grab_scan();
    expect_scan("R4", 20'h54321, 1, 0, 0);
    grab_scan();
    expect_scan("R4", 20'h54321, 0, 0, 0);
  endtask

  task automatic t_no_mix();
    sync_d5();
    fork
      grab_scan();
      begin
        repeat (25) @(negedge clk);
        send(20'h98765);
        repeat (20) @(negedge clk);
        send(20'h13579);
      end
    join
    expect_scan("R6", 20'h54321, 0, 0, 0);
    grab_scan();
    expect_scan("R6", 20'h13579, 1, 0, 0);
  endtask

  task automatic t_over_range();
    sync_d5();
    repeat (10) @(negedge clk);
    over_range = 1'b1;
    sync_d5();
    grab_scan();
    expect_scan("R9", 20'h13579, 0, 1, 0);
    fork
      grab_scan();
      begin
        repeat (30) @(negedge clk);
        send(20'h24680);
      end
    join
    expect_scan("R9", 20'h13579, 0, 1, 1);
    grab_scan();
    expect_scan("R9", 20'h24680, 1, 1, 0);
    over_range = 1'b0;
    grab_scan();
    expect_scan("R9", 20'h24680, 0, 1, 1);
    grab_scan();
    expect_scan("R8", 20'h24680, 0, 0, 0);
  endtask

  task automatic t_collision();
    repeat (ND * DW - 1) @(negedge clk);
    chk("R7", "select in last cycle of scan", digit_sel, 5'b00001);
    send(20'h70605);
    chk("R7", "select after scan-end edge", digit_sel, 5'b10000);
    grab_scan();
    expect_scan("R7", 20'h24680, 0, 0, 0);
    grab_scan();
    expect_scan("R7", 20'h70605, 1, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_no_mix();
    t_over_range();
    t_collision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule